// File: doc/BRIEF.md
# Vector Instruction Sequencer

This block is the sequencing front end of a vector engine. It fetches 32-bit instruction words from an instruction store and sorts each one by its top bit. A vector-class word has its fields decoded and is broadcast one cycle later to every processing element of an array. A control-class word runs inside the sequencer. The sequencer owns eight 16-bit scalar registers, a small add/subtract unit, jump and branch-on-zero logic, a hardware counter for a single non-nested loop, and a load/store port to a word memory.

While the sequencer runs its own work (arithmetic, branches, loads, stores, loop set-up, or a stall on a pending load), the array sees an idle broadcast. Register 0 is hard-wired to zero and gives immediate operations their base. A load places its returned word in register 1 and nowhere else, so software copies it out with a later instruction. The pipeline has two stages: fetch, then decode/execute. A taken branch, a jump, a loop wrap or a load discards the single word already fetched behind it.

Top module: `vsc_top`

## Requirements
- R1: While reset is held, `pe_valid`, `mem_req` and `imem_addr` are all zero, and after release the first fetch is from address 0.
- R2: A word with bit 31 set is a vector instruction. The cycle after it is decoded, `pe_valid` is 1 and the broadcast carries op = bits 30:26, ra = bits 25:23, rb = bits 22:20 and imm = bits 15:0. In every other cycle `pe_valid` is 0 and all broadcast fields are zero.
- R3: Register 0 reads as zero. A write aimed at it (for example ADDI with ra=0) has no effect.
- R4: Control ops (bit 31 clear) use the same field positions. ADDI (op 1) writes R[ra] = R[rb] + imm. ADD (op 2) writes R[ra] = R[ra] + R[rb]. SUB (op 3) writes R[ra] = R[ra] - R[rb]. All results wrap modulo 2^16, and a result is visible to the very next instruction.
- R5: LD (op 7) issues one read of address R[rb] + imm and stalls until `mem_rvalid`. The returned word goes only into register 1, and no broadcast occurs during the stall.
- R6: ST (op 8) issues one write with `mem_we` = 1, address R[rb] + imm and data R[ra].
- R7: JMP (op 4) moves the PC to imm and discards the one word fetched behind it.
- R8: BZ (op 5) jumps to imm and discards one fetched word when R[ra] is zero. Otherwise it falls through with no effect.
- R9: LOOP (op 6) loads the count from R[ra] and the end address from imm. The body runs from the next word through the end word. Each time the end word executes with a nonzero count, the count decrements and control returns to the body start, so the body runs count+1 times.
- R10: A word with any of bits 19:16 set does nothing: no broadcast, no register write and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | PCW | Fetch address |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| pe_valid | output | 1 | Broadcast holds a vector instruction |
| pe_op | output | 5 | Broadcast opcode |
| pe_ra | output | 3 | Broadcast first register field |
| pe_rb | output | 3 | Broadcast second register field |
| pe_imm | output | 16 | Broadcast immediate |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | DW | Request address |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |

## Verification
The assertions assume that the memory returns `mem_rvalid` only while a load is outstanding, and exactly once per read. They also assume that the instruction store answers in the same cycle as the fetch address. The bench's memory model sees each read request on a falling edge, waits two cycles, and then raises `mem_rvalid` for a single cycle, so both conditions hold. The program never starts a loop inside another loop.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
    localparam int unsigned IW     = 32;
    localparam int unsigned OPW    = 5;
    localparam int unsigned RIW    = 3;
    localparam int unsigned IMMW   = 16;
    localparam int unsigned NREG   = 1 << RIW;
    localparam int unsigned MEMREG = 1;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 5'd0,
        OP_ADDI = 5'd1,
        OP_ADD  = 5'd2,
        OP_SUB  = 5'd3,
        OP_JMP  = 5'd4,
        OP_BZ   = 5'd5,
        OP_LOOP = 5'd6,
        OP_LD   = 5'd7,
        OP_ST   = 5'd8
    } ctl_op_e;

    typedef enum logic {
        ALU_ADD = 1'b0,
        ALU_SUB = 1'b1
    } alu_fn_e;

    typedef struct packed {
        logic            vec;
        logic [OPW-1:0]  op;
        logic [RIW-1:0]  ra;
        logic [RIW-1:0]  rb;
        logic [3:0]      rsvd;
        logic [IMMW-1:0] imm;
    } instr_t;

    typedef struct packed {
        logic    legal;
        logic    is_vec;
        logic    rf_we;
        logic    use_imm;
        alu_fn_e fn;
        logic    is_jmp;
        logic    is_bz;
        logic    is_loop;
        logic    is_ld;
        logic    is_st;
    } ctl_t;
endpackage

// File: rtl/vsc_decode.sv
module vsc_decode
    import vsc_pkg::*;
(
    input  instr_t ir,
    output ctl_t   ctl
);
    always_comb begin
        ctl       = '0;
        ctl.fn    = ALU_ADD;
        ctl.legal = (ir.rsvd == '0);
        if (ctl.legal) begin
            if (ir.vec) begin
                ctl.is_vec = 1'b1;
            end else begin
                case (ctl_op_e'(ir.op))
                    OP_ADDI: begin ctl.rf_we = 1'b1; ctl.use_imm = 1'b1; end
                    OP_ADD:  begin ctl.rf_we = 1'b1; end
                    OP_SUB:  begin ctl.rf_we = 1'b1; ctl.fn = ALU_SUB; end
                    OP_JMP:  ctl.is_jmp = 1'b1;
                    OP_BZ:   ctl.is_bz = 1'b1;
                    OP_LOOP: ctl.is_loop = 1'b1;
                    OP_LD:   begin ctl.is_ld = 1'b1; ctl.use_imm = 1'b1; end
                    OP_ST:   begin ctl.is_st = 1'b1; ctl.use_imm = 1'b1; end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/vsc_alu.sv
module vsc_alu
    import vsc_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_fn_e       fn,
    output logic [DW-1:0] y
);
    always_comb begin
        case (fn)
            ALU_SUB: y = a - b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/vsc_regfile.sv
module vsc_regfile
    import vsc_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RIW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RIW-1:0] raddr_a,
    output logic [DW-1:0]  rdata_a,
    input  logic [RIW-1:0] raddr_b,
    output logic [DW-1:0]  rdata_b
);
    logic [DW-1:0] rf_d [NREG];
    logic [DW-1:0] rf_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign rf_d[g] = '0;
        end else begin : g_gpr
            assign rf_d[g] = (we && waddr == RIW'(g)) ? wdata : rf_q[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= rf_d[i];
        end
    end

    assign rdata_a = rf_q[raddr_a];
    assign rdata_b = rf_q[raddr_b];

    // R3
    r0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_a == '0) |-> (rdata_a == '0));
endmodule

// File: rtl/vsc_top.sv
module vsc_top
    import vsc_pkg::*;
#(
    parameter int unsigned DW  = 16,
    parameter int unsigned PCW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PCW-1:0]  imem_addr,
    input  logic [IW-1:0]   imem_data,
    output logic            pe_valid,
    output logic [OPW-1:0]  pe_op,
    output logic [RIW-1:0]  pe_ra,
    output logic [RIW-1:0]  pe_rb,
    output logic [IMMW-1:0] pe_imm,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_rvalid,
    input  logic [DW-1:0]   mem_rdata
);
    typedef struct packed {
        logic [PCW-1:0]  pc;
        instr_t          ir;
        logic            ir_v;
        logic [PCW-1:0]  ir_pc;
        logic            wait_ld;
        logic            loop_on;
        logic [DW-1:0]   loop_cnt;
        logic [PCW-1:0]  loop_start;
        logic [PCW-1:0]  loop_end;
        logic            pe_v;
        logic [OPW-1:0]  pe_op;
        logic [RIW-1:0]  pe_ra;
        logic [RIW-1:0]  pe_rb;
        logic [IMMW-1:0] pe_imm;
        logic            mreq;
        logic            mwe;
        logic [DW-1:0]   maddr;
        logic [DW-1:0]   mwdata;
    } st_t;

    st_t q, d;

    ctl_t           ctl;
    logic [DW-1:0]  rd_a, rd_b, alu_a, alu_b, alu_y, imm_x;
    logic           rf_we;
    logic [RIW-1:0] rf_wa;
    logic [DW-1:0]  rf_wd;
    logic           redirect, take, at_end, loop_hit, loop_step;
    logic [PCW-1:0] target;

    vsc_decode u_dec (
        .ir  (q.ir),
        .ctl (ctl)
    );

    vsc_regfile #(.DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_wa),
        .wdata   (rf_wd),
        .raddr_a (q.ir.ra),
        .rdata_a (rd_a),
        .raddr_b (q.ir.rb),
        .rdata_b (rd_b)
    );

    assign imm_x = DW'(q.ir.imm);
    assign alu_a = ctl.use_imm ? rd_b  : rd_a;
    assign alu_b = ctl.use_imm ? imm_x : rd_b;

    vsc_alu #(.DW(DW)) u_alu (
        .a  (alu_a),
        .b  (alu_b),
        .fn (ctl.fn),
        .y  (alu_y)
    );

    always_comb begin
        d = q;
        d.pe_v   = 1'b0;
        d.pe_op  = '0;
        d.pe_ra  = '0;
        d.pe_rb  = '0;
        d.pe_imm = '0;
        d.mreq   = 1'b0;
        d.mwe    = 1'b0;
        d.maddr  = '0;
        d.mwdata = '0;
        rf_we    = 1'b0;
        rf_wa    = '0;
        rf_wd    = '0;
        redirect = 1'b0;
        take     = 1'b0;
        at_end   = 1'b0;
        loop_hit = 1'b0;
        loop_step = 1'b0;
        target   = q.ir_pc + 1'b1;

        // fetch stage default
        d.ir    = instr_t'(imem_data);
        d.ir_v  = 1'b1;
        d.ir_pc = q.pc;
        d.pc    = q.pc + 1'b1;

        if (q.wait_ld) begin
            if (mem_rvalid) begin
                rf_we     = 1'b1;
                rf_wa     = RIW'(MEMREG);
                rf_wd     = mem_rdata;
                d.wait_ld = 1'b0;
            end else begin
                d.ir    = q.ir;
                d.ir_v  = 1'b0;
                d.ir_pc = q.ir_pc;
                d.pc    = q.pc;
            end
        end else if (q.ir_v) begin
            at_end   = q.loop_on && (q.ir_pc == q.loop_end);
            loop_hit = at_end && (q.loop_cnt != '0);
            if (loop_hit) target = q.loop_start;

            if (ctl.is_vec) begin
                d.pe_v   = 1'b1;
                d.pe_op  = q.ir.op;
                d.pe_ra  = q.ir.ra;
                d.pe_rb  = q.ir.rb;
                d.pe_imm = q.ir.imm;
            end
            if (ctl.rf_we) begin
                rf_we = 1'b1;
                rf_wa = q.ir.ra;
                rf_wd = alu_y;
            end
            if (ctl.is_ld) begin
                d.mreq    = 1'b1;
                d.maddr   = alu_y;
                d.wait_ld = 1'b1;
                redirect  = 1'b1;
            end
            if (ctl.is_st) begin
                d.mreq   = 1'b1;
                d.mwe    = 1'b1;
                d.maddr  = alu_y;
                d.mwdata = rd_a;
            end
            if (ctl.is_loop) begin
                d.loop_on    = 1'b1;
                d.loop_cnt   = rd_a;
                d.loop_start = q.ir_pc + 1'b1;
                d.loop_end   = q.ir.imm[PCW-1:0];
            end

            take = ctl.is_jmp || (ctl.is_bz && rd_a == '0);
            if (take) begin
                redirect = 1'b1;
                target   = q.ir.imm[PCW-1:0];
            end else if (at_end) begin
                if (loop_hit) begin
                    loop_step  = 1'b1;
                    d.loop_cnt = q.loop_cnt - 1'b1;
                    redirect   = 1'b1;
                end else begin
                    d.loop_on = 1'b0;
                end
            end

            if (redirect) begin
                d.pc   = target;
                d.ir_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign imem_addr = q.pc;
    assign pe_valid  = q.pe_v;
    assign pe_op     = q.pe_op;
    assign pe_ra     = q.pe_ra;
    assign pe_rb     = q.pe_rb;
    assign pe_imm    = q.pe_imm;
    assign mem_req   = q.mreq;
    assign mem_we    = q.mwe;
    assign mem_addr  = q.maddr;
    assign mem_wdata = q.mwdata;

    // R2
    pe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.pe_v |-> (q.pe_op == '0 && q.pe_ra == '0 && q.pe_rb == '0 && q.pe_imm == '0));

    // R2
    stall_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wait_ld && $past(q.wait_ld)) |-> !q.pe_v);

    // R5
    ld_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mreq && !q.mwe) |-> q.wait_ld);

    // R5
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wait_ld && $past(q.wait_ld)) |-> !q.mreq);

    // R5
    rvalid_expect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> q.wait_ld);

    // R7
    redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !q.ir_v);

    // R9
    loop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_step |=> (q.loop_cnt == $past(q.loop_cnt) - 1'b1));
endmodule

// File: tb/vsc_top_bench.sv
module vsc_top_bench;
    localparam int DW  = 16;
    localparam int PCW = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [PCW-1:0] imem_addr;
    logic [31:0]    imem_data;
    logic           pe_valid;
    logic [4:0]     pe_op;
    logic [2:0]     pe_ra, pe_rb;
    logic [15:0]    pe_imm;
    logic           mem_req, mem_we;
    logic [DW-1:0]  mem_addr, mem_wdata;
    logic           mem_rvalid;
    logic [DW-1:0]  mem_rdata;

    always #5 clk = ~clk;

    logic [31:0] prog [1 << PCW];
    assign imem_data = prog[imem_addr];

    vsc_top #(.DW(DW), .PCW(PCW)) u_vsc_top (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .pe_valid(pe_valid), .pe_op(pe_op), .pe_ra(pe_ra), .pe_rb(pe_rb), .pe_imm(pe_imm),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int total = 0;
    int bad   = 0;

    typedef struct { logic [26:0] fields; string tag; } pe_item_t;
    typedef struct { logic [31:0] aw; string tag; } st_item_t;
    pe_item_t pe_q[$];
    st_item_t st_q[$];

    function automatic logic [31:0] enc(bit vec, int op, int ra, int rb, int imm);
        return {vec, 5'(op), 3'(ra), 3'(rb), 4'b0000, 16'(imm)};
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic exp_pe(int op, int ra, int rb, int imm, string tag);
        pe_item_t it;
        it.fields = {5'(op), 3'(ra), 3'(rb), 16'(imm)};
        it.tag = tag;
        pe_q.push_back(it);
    endtask

    task automatic exp_st(int addr, int data, string tag);
        st_item_t it;
        it.aw = {16'(addr), 16'(data)};
        it.tag = tag;
        st_q.push_back(it);
    endtask

    function automatic logic [15:0] mem_model(logic [15:0] a);
        case (a)
            16'h0020: return 16'h1234;
            16'h0021: return 16'hBEEF;
            default:  return 16'h0000;
        endcase
    endfunction

    // monitor: pops expected items as outputs appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pe_valid) begin
                    if (pe_q.size() == 0) begin
                        check(1'b0, "R2", "unexpected broadcast", {5'b0, pe_op, pe_ra, pe_rb, pe_imm}, 32'h0);
                    end else begin
                        pe_item_t it;
                        it = pe_q.pop_front();
                        check({pe_op, pe_ra, pe_rb, pe_imm} == it.fields, it.tag, "broadcast",
                              {5'b0, pe_op, pe_ra, pe_rb, pe_imm}, {5'b0, it.fields});
                    end
                end
                if (mem_req && mem_we) begin
                    if (st_q.size() == 0) begin
                        check(1'b0, "R6", "unexpected store", {mem_addr, mem_wdata}, 32'h0);
                    end else begin
                        st_item_t it;
                        it = st_q.pop_front();
                        check({mem_addr, mem_wdata} == it.aw, it.tag, "store",
                              {mem_addr, mem_wdata}, it.aw);
                    end
                end
            end
        end
    end

    // memory responder: two-cycle read latency, one-cycle valid pulse
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req && !mem_we) begin
                logic [15:0] a;
                a = mem_addr;
                repeat (2) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = mem_model(a);
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = '0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog: actual %h expected %h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        for (int i = 0; i < (1 << PCW); i++) prog[i] = enc(0, 4, 0, 0, i);
        prog[0]  = enc(0, 1, 2, 0, 5);          // r2 = 5
        prog[1]  = enc(0, 1, 0, 0, 7);          // write to r0 ignored
        prog[2]  = enc(0, 8, 0, 0, 16'h10);     // st r0
        prog[3]  = enc(0, 8, 2, 0, 16'h11);     // st r2
        prog[4]  = enc(1, 3, 1, 2, 16'hABCD);   // vector
        prog[5]  = enc(0, 1, 3, 0, 16'hFFFF);   // r3 = ffff
        prog[6]  = enc(0, 1, 4, 0, 2);          // r4 = 2
        prog[7]  = enc(0, 2, 3, 4, 0);          // r3 += r4 -> 1
        prog[8]  = enc(0, 3, 4, 2, 0);          // r4 -= r2 -> fffd
        prog[9]  = enc(0, 8, 3, 0, 16'h12);
        prog[10] = enc(0, 8, 4, 0, 16'h13);
        prog[11] = enc(0, 7, 0, 0, 16'h20);     // ld
        prog[12] = enc(0, 8, 1, 0, 16'h14);     // st r1
        prog[13] = enc(0, 1, 5, 0, 2);          // count
        prog[14] = enc(0, 1, 6, 0, 0);
        prog[15] = enc(0, 6, 5, 0, 17);         // loop, end 17
        prog[16] = enc(0, 1, 6, 6, 3);          // r6 += 3
        prog[17] = enc(1, 7, 0, 0, 16'h0011);
        prog[18] = enc(0, 8, 6, 0, 16'h15);
        prog[19] = enc(0, 5, 2, 0, 30);         // bz not taken
        prog[20] = enc(1, 9, 0, 0, 1);
        prog[21] = enc(0, 5, 0, 0, 24);         // bz taken
        prog[22] = enc(1, 10, 0, 0, 0);         // discarded
        prog[23] = enc(0, 8, 2, 0, 16'h16);     // skipped
        prog[24] = enc(0, 4, 0, 0, 26);         // jmp
        prog[25] = enc(1, 11, 0, 0, 0);         // discarded
        prog[26] = enc(1, 31, 7, 7, 16'hFFFF);
        prog[27] = enc(0, 7, 0, 2, 16'h1C);     // ld [r2+1c]
        prog[28] = enc(0, 8, 1, 0, 16'h17);
        prog[29] = enc(1, 13, 1, 1, 1) | 32'h0001_0000;  // reserved bit set
        prog[30] = enc(1, 14, 0, 0, 3);
        prog[31] = enc(0, 4, 0, 0, 31);         // halt

        exp_st(16'h10, 0, "R3");
        exp_pe(3, 1, 2, 16'hABCD, "R2");
        exp_st(16'h11, 5, "R6");
        exp_st(16'h12, 1, "R4");
        exp_st(16'h13, 16'hFFFD, "R4");
        exp_st(16'h14, 16'h1234, "R5");
        exp_pe(7, 0, 0, 16'h11, "R9");
        exp_pe(7, 0, 0, 16'h11, "R9");
        exp_pe(7, 0, 0, 16'h11, "R9");
        exp_st(16'h15, 9, "R9");
        exp_pe(9, 0, 0, 1, "R8");
        exp_pe(31, 7, 7, 16'hFFFF, "R7");
        exp_st(16'h17, 16'hBEEF, "R5");
        exp_pe(14, 0, 0, 3, "R10");

        repeat (3) @(negedge clk);
        check(pe_valid == 1'b0, "R1", "pe_valid in reset", 32'(pe_valid), 32'h0);
        check(mem_req == 1'b0, "R1", "mem_req in reset", 32'(mem_req), 32'h0);
        check(imem_addr == '0, "R1", "imem_addr in reset", 32'(imem_addr), 32'h0);
        rst_n = 1'b1;

        repeat (300) @(negedge clk);
        check(pe_q.size() == 0, "R8", "broadcasts missing", 32'(pe_q.size()), 32'h0);
        check(st_q.size() == 0, "R6", "stores missing", 32'(st_q.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule